// File: doc/BRIEF.md
# Paired 8-bit register file

This block is the register storage of a small 8-bit processor core. It holds an accumulator, six general byte registers and a 16-bit stack pointer. The six general registers can be addressed one byte at a time or as three fixed 16-bit pairs. The block also holds a single carry flag. Each clock it takes a small operation code, a byte select, a pair select and write data. It performs at most one update, and it gives out combinational read values for a byte select and a pair select.

The 16-bit work sits inside the block: pair load, pair increment and decrement, and addition of a pair into the high/low pair. A double-pair exchange and the copy of the high/low pair into the stack pointer are also here. The high/low pair is always visible on its own port, so the surrounding core can take a computed jump target from it. The core's decoder drives the operation code. The core's byte ALU writes its results through the byte write path, and the core's flag logic owns every flag except carry.

Top module: `pairfile_top`

## Requirements
- R1: A synchronous active-high `rst` clears all seven byte registers, the stack pointer and carry to zero at the next rising edge.
- R2: Operation code 1 writes `wdata8_i` into the byte chosen by `wsel8_i` (000 B, 001 C, 010 D, 011 E, 100 H, 101 L, 111 A). Byte code 110 selects nothing: a write to it is ignored, and reading it returns 0.
- R3: `rdata8_o` shows the byte chosen by `rsel8_i`, using the same codes. `rdata16_o` shows the pair chosen by `rsel16_i` (00 BC, 01 DE, 10 HL, 11 SP), and the first-named register of a pair is the high byte. Both reads are combinational, and writes appear after the next rising edge.
- R4: Operation code 2 loads `wdata16_i` into the pair chosen by `psel_i`.
- R5: Operation codes 3 and 4 increment or decrement the selected pair by one, wrapping modulo 65536, and leave carry unchanged.
- R6: Operation code 5 adds the pair chosen by `psel_i` into HL, wrapping modulo 65536. Carry becomes the carry out of bit 15.
- R7: Operation code 5 with the HL select shifts HL left by one, and the old bit 15 goes into carry.
- R8: Operation code 6 swaps the complete contents of HL and DE in a single cycle.
- R9: Operation code 7 copies HL into SP. `hl_o` always shows the current HL value for use as a jump target.
- R10: Operation code 0 and codes 8 to 15 change no register and leave carry unchanged. No pair operation alters A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Operation code |
| wsel8_i | input | 3 | Byte select for byte writes |
| psel_i | input | 2 | Pair select for 16-bit operations |
| wdata8_i | input | 8 | Byte write data |
| wdata16_i | input | 16 | Pair load data |
| rsel8_i | input | 3 | Byte read select |
| rsel16_i | input | 2 | Pair read select |
| rdata8_o | output | 8 | Selected byte |
| rdata16_o | output | 16 | Selected pair |
| hl_o | output | 16 | Current HL value (jump target) |
| carry_o | output | 1 | Carry flag |

## Verification
Two functions can fall in the same cycle. A pair update can read and write the same registers in one edge, as in HL added to itself, the HL/DE exchange, or HL copied into SP. Separately, a byte write can target a register that a later pair operation depends on. Random operation streams give back-to-back byte writes and pair updates on overlapping registers, and directed cases force the self-referencing add and the exchange. After every edge the bench reads all bytes and pairs through the read ports and compares them with a model that takes its operands from the state before that edge.

// File: rtl/pairfile_pkg.sv
package pairfile_pkg;

    localparam int NBYTE = 8;

    typedef enum logic [3:0] {
        OP_IDLE   = 4'd0,
        OP_PUT8   = 4'd1,
        OP_LOAD16 = 4'd2,
        OP_INC16  = 4'd3,
        OP_DEC16  = 4'd4,
        OP_ADDHL  = 4'd5,
        OP_SWAPDH = 4'd6,
        OP_HL2SP  = 4'd7
    } pf_op_e;

    localparam logic [1:0] PSEL_BC = 2'd0;
    localparam logic [1:0] PSEL_DE = 2'd1;
    localparam logic [1:0] PSEL_HL = 2'd2;
    localparam logic [1:0] PSEL_SP = 2'd3;

    localparam logic [2:0] BSEL_HOLE = 3'd6;
    localparam logic [2:0] BSEL_ACC  = 3'd7;

endpackage

// File: rtl/pf_arith.sv
module pf_arith #(
    parameter int W = 16
) (
    input  logic [W-1:0] operand_i,
    input  logic [W-1:0] hl_i,
    output logic [W-1:0] inc_o,
    output logic [W-1:0] dec_o,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W:0] wide_sum;

    always_comb begin
        inc_o    = operand_i + ONE;
        dec_o    = operand_i - ONE;
        wide_sum = {1'b0, hl_i} + {1'b0, operand_i};
        sum_o    = wide_sum[W-1:0];
        cout_o   = wide_sum[W];
    end

endmodule

// File: rtl/pf_store.sv
module pf_store
    import pairfile_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr8_en,
    input  logic [2:0]                  wr8_sel,
    input  logic [BW-1:0]               wr8_data,
    input  logic                        wr16_en,
    input  logic [1:0]                  wr16_sel,
    input  logic [2*BW-1:0]             wr16_data,
    input  logic                        swap_en,
    input  logic                        cy_en,
    input  logic                        cy_data,
    output logic [NBYTE-1:0][BW-1:0]    bytes_o,
    output logic [2*BW-1:0]             sp_o,
    output logic                        cy_o
);
    localparam int PW = 2 * BW;

    logic [BW-1:0] q [NBYTE];
    logic [PW-1:0] sp_q;
    logic          cy_q;

    for (genvar i = 0; i < NBYTE; i++) begin : g_byte
        localparam logic [2:0] ME = 3'(i);
        if (i == 6) begin : g_hole
            assign q[i] = '0;
        end else if (i == 7) begin : g_acc
            always_ff @(posedge clk) begin
                if (rst)
                    q[i] <= '0;
                else if (wr8_en && wr8_sel == ME)
                    q[i] <= wr8_data;
            end
        end else begin : g_paired
            localparam logic [1:0] MYPAIR = 2'(i / 2);
            localparam bit         HIGH   = (i % 2) == 0;
            localparam bit         SWAPS  = (i >= 2);
            localparam int         PART   = i ^ 6;
            always_ff @(posedge clk) begin
                if (rst)
                    q[i] <= '0;
                else if (wr8_en && wr8_sel == ME)
                    q[i] <= wr8_data;
                else if (wr16_en && wr16_sel == MYPAIR)
                    q[i] <= HIGH ? wr16_data[PW-1:BW] : wr16_data[BW-1:0];
                else if (SWAPS && swap_en)
                    q[i] <= q[PART];
            end
        end
        assign bytes_o[i] = q[i];
    end

    always_ff @(posedge clk) begin
        if (rst)
            sp_q <= '0;
        else if (wr16_en && wr16_sel == PSEL_SP)
            sp_q <= wr16_data;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cy_q <= 1'b0;
        else if (cy_en)
            cy_q <= cy_data;
    end

    assign sp_o = sp_q;
    assign cy_o = cy_q;

endmodule

// File: rtl/pairfile_top.sv
module pairfile_top
    import pairfile_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op_i,
    input  logic [2:0]        wsel8_i,
    input  logic [1:0]        psel_i,
    input  logic [BW-1:0]     wdata8_i,
    input  logic [2*BW-1:0]   wdata16_i,
    input  logic [2:0]        rsel8_i,
    input  logic [1:0]        rsel16_i,
    output logic [BW-1:0]     rdata8_o,
    output logic [2*BW-1:0]   rdata16_o,
    output logic [2*BW-1:0]   hl_o,
    output logic              carry_o
);
    localparam int PW = 2 * BW;

    pf_op_e                  op;
    logic [NBYTE-1:0][BW-1:0] bytes_w;
    logic [PW-1:0]           sp_w, bc_w, de_w, hl_w, sel_pair_w;
    logic [BW-1:0]           acc_w;
    logic [PW-1:0]           inc_w, dec_w, sum_w;
    logic                    sum_cy;
    logic                    cy_w;

    logic                    wr8_en;
    logic                    wr16_en;
    logic [1:0]              wr16_sel;
    logic [PW-1:0]           wr16_data;
    logic                    swap_en;
    logic                    cy_en;

    assign op = pf_op_e'(op_i);

    function automatic logic [PW-1:0] pick_pair(
        input logic [1:0]    sel,
        input logic [PW-1:0] bc, de, hl, sp
    );
        unique case (sel)
            PSEL_BC: pick_pair = bc;
            PSEL_DE: pick_pair = de;
            PSEL_HL: pick_pair = hl;
            default: pick_pair = sp;
        endcase
    endfunction

    assign bc_w  = {bytes_w[0], bytes_w[1]};
    assign de_w  = {bytes_w[2], bytes_w[3]};
    assign hl_w  = {bytes_w[4], bytes_w[5]};
    assign acc_w = bytes_w[BSEL_ACC];

    assign sel_pair_w = pick_pair(psel_i, bc_w, de_w, hl_w, sp_w);

    pf_arith #(.W(PW)) u_arith (
        .operand_i (sel_pair_w),
        .hl_i      (hl_w),
        .inc_o     (inc_w),
        .dec_o     (dec_w),
        .sum_o     (sum_w),
        .cout_o    (sum_cy)
    );

    always_comb begin
        wr8_en    = 1'b0;
        wr16_en   = 1'b0;
        wr16_sel  = psel_i;
        wr16_data = wdata16_i;
        swap_en   = 1'b0;
        cy_en     = 1'b0;
        unique case (op)
            OP_PUT8:   wr8_en = (wsel8_i != BSEL_HOLE);
            OP_LOAD16: wr16_en = 1'b1;
            OP_INC16: begin
                wr16_en   = 1'b1;
                wr16_data = inc_w;
            end
            OP_DEC16: begin
                wr16_en   = 1'b1;
                wr16_data = dec_w;
            end
            OP_ADDHL: begin
                wr16_en   = 1'b1;
                wr16_sel  = PSEL_HL;
                wr16_data = sum_w;
                cy_en     = 1'b1;
            end
            OP_SWAPDH: swap_en = 1'b1;
            OP_HL2SP: begin
                wr16_en   = 1'b1;
                wr16_sel  = PSEL_SP;
                wr16_data = hl_w;
            end
            default: ;
        endcase
    end

    pf_store #(.BW(BW)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr8_en    (wr8_en),
        .wr8_sel   (wsel8_i),
        .wr8_data  (wdata8_i),
        .wr16_en   (wr16_en),
        .wr16_sel  (wr16_sel),
        .wr16_data (wr16_data),
        .swap_en   (swap_en),
        .cy_en     (cy_en),
        .cy_data   (sum_cy),
        .bytes_o   (bytes_w),
        .sp_o      (sp_w),
        .cy_o      (cy_w)
    );

    assign rdata8_o  = bytes_w[rsel8_i];
    assign rdata16_o = pick_pair(rsel16_i, bc_w, de_w, hl_w, sp_w);
    assign hl_o      = hl_w;
    assign carry_o   = cy_w;

endmodule

// File: rtl/pairfile_check.sv
module pairfile_check
    import pairfile_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [3:0]  op_i,
    input logic [1:0]  psel_i,
    input logic [15:0] hl,
    input logic [15:0] de,
    input logic [15:0] sp,
    input logic [7:0]  acc,
    input logic        cy
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (hl == 16'd0 && de == 16'd0 && sp == 16'd0 && acc == 8'd0 && !cy));

    assert_incdec_keeps_carry_R5: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_INC16 || op_i == OP_DEC16) |=> $stable(cy));

    assert_sp_inc_wraps_R5: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_INC16 && psel_i == PSEL_SP) |=> sp == $past(sp) + 16'd1);

    assert_hl_double_R7: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_ADDHL && psel_i == PSEL_HL)
        |=> (hl == {$past(hl[14:0]), 1'b0} && cy == $past(hl[15])));

    assert_swap_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_SWAPDH) |=> (hl == $past(de) && de == $past(hl)));

    assert_sp_from_hl_R9: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_HL2SP) |=> (sp == $past(hl) && $stable(hl)));

    assert_idle_no_change_R10: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_IDLE || op_i[3])
        |=> ($stable(hl) && $stable(de) && $stable(sp) && $stable(acc) && $stable(cy)));

    assert_pair_ops_keep_acc_R10: assert property (@(posedge clk) disable iff (rst)
        (op_i != OP_PUT8) |=> $stable(acc));

endmodule

bind pairfile_top pairfile_check u_pairfile_check (
    .clk    (clk),
    .rst    (rst),
    .op_i   (op_i),
    .psel_i (psel_i),
    .hl     (hl_w),
    .de     (de_w),
    .sp     (sp_w),
    .acc    (acc_w),
    .cy     (carry_o)
);

// File: tb/pairfile_top_tb_top.sv
module pairfile_top_tb_top;

    localparam int CLK_PERIOD = 40;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  op_i;
    logic [2:0]  wsel8_i;
    logic [1:0]  psel_i;
    logic [7:0]  wdata8_i;
    logic [15:0] wdata16_i;
    logic [2:0]  rsel8_i;
    logic [1:0]  rsel16_i;
    logic [7:0]  rdata8_o;
    logic [15:0] rdata16_o;
    logic [15:0] hl_o;
    logic        carry_o;

    int total = 0;
    int bad   = 0;

    logic [7:0]  m_b [8];
    logic [15:0] m_sp;
    logic        m_cy;

    always #(CLK_PERIOD/2) clk = ~clk;

    pairfile_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .op_i      (op_i),
        .wsel8_i   (wsel8_i),
        .psel_i    (psel_i),
        .wdata8_i  (wdata8_i),
        .wdata16_i (wdata16_i),
        .rsel8_i   (rsel8_i),
        .rsel16_i  (rsel16_i),
        .rdata8_o  (rdata8_o),
        .rdata16_o (rdata16_o),
        .hl_o      (hl_o),
        .carry_o   (carry_o)
    );

    function automatic logic [15:0] m_pair(input logic [1:0] p);
        case (p)
            2'd0:    return {m_b[0], m_b[1]};
            2'd1:    return {m_b[2], m_b[3]};
            2'd2:    return {m_b[4], m_b[5]};
            default: return m_sp;
        endcase
    endfunction

    task automatic m_set_pair(input logic [1:0] p, input logic [15:0] v);
        case (p)
            2'd0: begin m_b[0] = v[15:8]; m_b[1] = v[7:0]; end
            2'd1: begin m_b[2] = v[15:8]; m_b[3] = v[7:0]; end
            2'd2: begin m_b[4] = v[15:8]; m_b[5] = v[7:0]; end
            default: m_sp = v;
        endcase
    endtask

    task automatic m_clear();
        for (int i = 0; i < 8; i++) m_b[i] = 8'h00;
        m_sp = 16'h0000;
        m_cy = 1'b0;
    endtask

    task automatic m_step(input logic [3:0] op, input logic [2:0] b, input logic [1:0] p,
                          input logic [7:0] w8, input logic [15:0] w16);
        logic [16:0] s;
        logic [15:0] t;
        case (op)
            4'd1: if (b != 3'd6) m_b[b] = w8;
            4'd2: m_set_pair(p, w16);
            4'd3: m_set_pair(p, m_pair(p) + 16'd1);
            4'd4: m_set_pair(p, m_pair(p) - 16'd1);
            4'd5: begin
                s = {1'b0, m_pair(2'd2)} + {1'b0, m_pair(p)};
                m_set_pair(2'd2, s[15:0]);
                m_cy = s[16];
            end
            4'd6: begin
                t = m_pair(2'd1);
                m_set_pair(2'd1, m_pair(2'd2));
                m_set_pair(2'd2, t);
            end
            4'd7: m_sp = m_pair(2'd2);
            default: ;
        endcase
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < 8; i++) begin
            rsel8_i = 3'(i);
            #1;
            chk({tag, " byte (R2,R3)"}, {8'h00, rdata8_o}, {8'h00, (i == 6) ? 8'h00 : m_b[i]});
        end
        for (int p = 0; p < 4; p++) begin
            rsel16_i = 2'(p);
            #1;
            chk({tag, " pair (R3)"}, rdata16_o, m_pair(2'(p)));
        end
        chk({tag, " carry"}, {15'd0, carry_o}, {15'd0, m_cy});
        chk({tag, " hl_o (R9)"}, hl_o, m_pair(2'd2));
    endtask

    task automatic apply(input string tag, input logic [3:0] op, input logic [2:0] b,
                         input logic [1:0] p, input logic [7:0] w8, input logic [15:0] w16);
        @(negedge clk);
        op_i = op; wsel8_i = b; psel_i = p; wdata8_i = w8; wdata16_i = w16;
        @(posedge clk);
        #1;
        m_step(op, b, p, w8, w16);
        check_all(tag);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1;
        op_i = 4'd0;
        @(posedge clk);
        #1;
        m_clear();
        check_all(tag);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; op_i = '0; wsel8_i = '0; psel_i = '0; wdata8_i = '0;
        wdata16_i = '0; rsel8_i = '0; rsel16_i = '0;
        m_clear();
        void'($urandom(32'd20240607));

        // R1: reset state
        do_reset("R1 reset");

        // R2: byte writes, including A and the hole code 110
        apply("R2 put B", 4'd1, 3'd0, 2'd0, 8'h12, 16'h0);
        apply("R2 put C", 4'd1, 3'd1, 2'd0, 8'h34, 16'h0);
        apply("R2 put A", 4'd1, 3'd7, 2'd0, 8'hA5, 16'h0);
        apply("R2 hole ignored", 4'd1, 3'd6, 2'd0, 8'hFF, 16'h0);

        // R4: pair loads, high byte first-named
        apply("R4 load DE", 4'd2, 3'd0, 2'd1, 8'h0, 16'hBEEF);
        apply("R4 load HL", 4'd2, 3'd0, 2'd2, 8'h0, 16'h8000);
        apply("R4 load SP", 4'd2, 3'd0, 2'd3, 8'h0, 16'hFFFF);

        // R6/R7: HL+HL sets carry, shifts left
        apply("R7 HL double", 4'd5, 3'd0, 2'd2, 8'h0, 16'h0);
        // R5: wrap with carry held at 1
        apply("R5 SP inc wrap", 4'd3, 3'd0, 2'd3, 8'h0, 16'h0);
        apply("R5 HL dec wrap", 4'd4, 3'd0, 2'd2, 8'h0, 16'h0);
        // R6: HL+DE with carry out
        apply("R6 add DE", 4'd5, 3'd0, 2'd1, 8'h0, 16'h0);
        apply("R6 add SP zero", 4'd5, 3'd0, 2'd3, 8'h0, 16'h0);

        // R8: exchange
        apply("R8 swap", 4'd6, 3'd0, 2'd0, 8'h0, 16'h0);
        // R9: SP from HL
        apply("R9 HL to SP", 4'd7, 3'd0, 2'd0, 8'h0, 16'h0);

        // R10: idle and unused codes
        apply("R10 idle", 4'd0, 3'd7, 2'd2, 8'h77, 16'h5555);
        apply("R10 unused 9", 4'd9, 3'd7, 2'd2, 8'h77, 16'h5555);
        apply("R10 unused 15", 4'd15, 3'd0, 2'd1, 8'h77, 16'h5555);

        // Random mix of operations
        for (int n = 0; n < 400; n++) begin
            logic [3:0] rop;
            if (n == 200) do_reset("R1 mid reset");
            rop = ($urandom % 5 == 0) ? 4'($urandom % 16) : 4'($urandom % 8);
            apply("rand R2-R10 mix", rop, 3'($urandom), 2'($urandom), 8'($urandom), 16'($urandom));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule